// File: doc/BRIEF.md
# Programmable Serial Line Transmitter

This block is the sending half of an asynchronous serial port. Bytes are pushed into a sixteen-entry queue. A shift engine takes them one at a time and drives them onto a single output line as framed characters. A small control word sets the shape of each frame: the character length, whether a parity bit is sent and how it is formed, the stop length, and a line-break override. A 16-bit divisor sets the speed. The divisor produces a sub-bit enable, and one bit lasts sixteen of those enables.

Two registered flags report progress. The first says the queue is empty and another byte may be written. The second says the whole transmitter has gone quiet, meaning the queue is empty and no frame is in flight. A clear input flushes the queue without cutting short the character already being shifted. The shape of a frame is captured when its character leaves the queue, so the control word may be changed while a frame is on the line.

Top module: `ser_tx_top`

## Requirements
- R1: After a synchronous reset, `txd` is 1 and both `hold_empty` and `xmit_empty` are 1.
- R2: A sub-bit enable fires once every `baud_div` clock cycles, and one line bit lasts 16 enables, so the start bit lasts 16×`baud_div` cycles. When `baud_div` is 0, no enable fires, frame progress stops and `txd` is held at 1 unless break is set.
- R3: A frame is a 0 start bit, followed by the data bits sent least significant first, followed by stop bits at 1. The idle line is 1. `line_cfg[1:0]` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: `line_cfg[3]`=1 inserts a parity bit after the data. `line_cfg[5:4]` chooses how it is formed: 00 makes the total number of ones in data plus parity odd, 01 makes it even, 10 sends a fixed 1, and 11 sends a fixed 0.
- R5: `line_cfg[2]`=0 gives one stop bit of 16 enables. `line_cfg[2]`=1 gives 24 enables for 5-bit characters and 32 enables for 6, 7 or 8-bit characters.
- R6: While `line_cfg[6]` is 1, `txd` is 0 from the next cycle on. The frame timing underneath keeps running.
- R7: The queue holds 16 bytes and sends them in the order written. A write into a full queue is dropped unless a byte leaves the queue in that same cycle, in which case the write is kept.
- R8: `fifo_clr` empties the queue and wins over a write in the same cycle. A character already taken for sending, including one taken in that same cycle, is still sent in full.
- R9: `hold_empty` shows, one cycle later, whether the queue is empty. `xmit_empty` shows, one cycle later, whether the queue is empty and no frame is in progress.
- R10: A new character is taken from the queue only on a sub-bit enable. When the queue holds data, the next start bit follows the last stop enable with no idle gap. The frame shape is taken from `line_cfg` in the cycle the character is taken.
- R11: `txd` is registered. It follows the internal line state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_byte` into the queue |
| wr_byte | input | 8 | Byte to send |
| fifo_clr | input | 1 | Flush the queue |
| line_cfg | input | 7 | Frame shape: [1:0] length, [2] long stop, [3] parity enable, [5:4] parity form, [6] break |
| baud_div | input | 16 | Clock cycles per sub-bit enable (0 stops the line) |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Queue empty |
| xmit_empty | output | 1 | Queue empty and no frame in progress |

## Verification
Two cases can fall in the same cycle. The first is a queue clear arriving in the cycle the shift engine takes the head byte. The second is a write into a full queue arriving in the cycle a byte leaves it. The clear case is provoked by running the divisor at 1, writing one byte and raising the clear in the very next cycle. The full-queue case is provoked by filling the queue while the divisor is 0, then restarting the line and writing on every cycle. A behavioural model in the bench keeps the queue as a list and each frame as a list of line levels, one per enable. It decides in each case whether the byte is sent and whether the write survives. The output pins are compared against the model on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } tx_phase_e;

  typedef struct packed {
    logic [1:0] wlen;       // 0..3 -> 5..8 data bits
    logic       stop_long;  // longer stop period
    logic       par_en;     // parity bit present
    logic [1:0] par_sel;    // parity form
  } frame_cfg_t;

  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] w);
    return d & (8'hFF >> (3'd3 - {1'b0, w}));
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic             full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && !clr && (!full || do_pop);
  assign head    = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R7

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (cnt == $past(cnt))); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty); // R8

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || divisor == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  AST_DIV_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |=> !tick); // R2

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       fifo_empty,
  input  logic [7:0] head,
  output logic       pop,
  output logic       busy,
  output logic       line
);
  localparam int HALF   = OVERSAMPLE / 2;
  localparam int TICK_W = $clog2(2 * OVERSAMPLE);

  tx_phase_e         phase;
  frame_cfg_t        cfg_q;
  logic [7:0]        sh;
  logic [2:0]        bidx;
  logic [TICK_W-1:0] tcnt;
  logic [TICK_W-1:0] last_tick;
  logic              par_bit;
  logic              seg_end, stop_end, ones;
  logic [2:0]        last_bit;

  always_comb begin
    if (phase == PH_STOP && cfg_q.stop_long)
      last_tick = (cfg_q.wlen == 2'b00) ? TICK_W'(OVERSAMPLE + HALF - 1)
                                        : TICK_W'(2 * OVERSAMPLE - 1);
    else
      last_tick = TICK_W'(OVERSAMPLE - 1);
  end

  assign busy     = (phase != PH_IDLE);
  assign seg_end  = tick && busy && (tcnt == last_tick);
  assign stop_end = seg_end && (phase == PH_STOP);
  assign pop      = tick && !fifo_empty && (!busy || stop_end);
  assign last_bit = 3'd4 + {1'b0, cfg_q.wlen};
  assign ones     = ^keep_bits(head, cfg.wlen);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cfg_q   <= '0;
      sh      <= '0;
      bidx    <= '0;
      tcnt    <= '0;
      par_bit <= 1'b0;
    end else if (pop) begin
      phase   <= PH_START;
      cfg_q   <= cfg;
      sh      <= head;
      bidx    <= '0;
      tcnt    <= '0;
      par_bit <= cfg.par_sel[1] ? ~cfg.par_sel[0]
                                : (cfg.par_sel[0] ? ones : ~ones);
    end else if (busy && tick) begin
      if (!seg_end) begin
        tcnt <= tcnt + TICK_W'(1);
      end else begin
        tcnt <= '0;
        case (phase)
          PH_START: begin
            phase <= PH_DATA;
            bidx  <= '0;
          end
          PH_DATA: begin
            if (bidx == last_bit) begin
              phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
            end else begin
              bidx <= bidx + 3'd1;
              sh   <= sh >> 1;
            end
          end
          PH_PAR:  phase <= PH_STOP;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (phase)
      PH_START: line = 1'b0;
      PH_DATA:  line = sh[0];
      PH_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tick)); // R10

  AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && busy) |=> (phase == $past(phase))); // R2

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import sertx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             fifo_clr,
  input  logic [6:0]       line_cfg,
  input  logic [DIV_W-1:0] baud_div,
  output logic             txd,
  output logic             hold_empty,
  output logic             xmit_empty
);
  frame_cfg_t cfg;
  logic       brk, tick, fifo_empty, pop, busy, line;
  logic [7:0] head;

  assign cfg.wlen      = line_cfg[1:0];
  assign cfg.stop_long = line_cfg[2];
  assign cfg.par_en    = line_cfg[3];
  assign cfg.par_sel   = line_cfg[5:4];
  assign brk           = line_cfg[6];

  sertx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr), .push(wr_en), .push_data(wr_byte),
    .pop(pop), .head(head), .empty(fifo_empty)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .divisor(baud_div), .tick(tick)
  );

  sertx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .fifo_empty(fifo_empty),
    .head(head), .pop(pop), .busy(busy), .line(line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd        <= 1'b1;
      hold_empty <= 1'b1;
      xmit_empty <= 1'b1;
    end else begin
      txd        <= brk ? 1'b0 : ((baud_div == '0) ? 1'b1 : line);
      hold_empty <= fifo_empty;
      xmit_empty <= fifo_empty && !busy;
    end
  end

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd); // R6

  AST_XMIT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    xmit_empty |-> hold_empty); // R9

  AST_STOPPED_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (baud_div == '0 && !brk) |=> txd); // R2

  AST_BUSY_NOT_XMIT: assert property (@(posedge clk) disable iff (rst)
    busy |=> !xmit_empty); // R9

endmodule

// File: tb/ser_tx_top_test.sv
`timescale 1ns/1ps
module ser_tx_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        fifo_clr = 1'b0;
  logic [6:0]  line_cfg = 7'h03;
  logic [15:0] baud_div = 16'd2;
  logic        txd, hold_empty, xmit_empty;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  ser_tx_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .fifo_clr(fifo_clr),
    .line_cfg(line_cfg), .baud_div(baud_div), .txd(txd),
    .hold_empty(hold_empty), .xmit_empty(xmit_empty)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int          m_cnt = 0;
  bit          m_tick = 0;
  bit          m_busy = 0;
  byte unsigned q[$];
  bit          lv_q[$];
  bit          e_txd = 1, e_hold = 1, e_xmit = 1;
  bit          m_lvl, m_ld, m_done;
  byte unsigned m_hd;

  function automatic void push_level(bit v, int n);
    for (int k = 0; k < n; k++) lv_q.push_back(v);
  endfunction

  function automatic void build_frame(byte unsigned b, logic [5:0] c);
    int n;
    int ones;
    bit p;
    n = 5 + int'(c[1:0]);
    ones = 0;
    lv_q.delete();
    push_level(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      push_level(b[i], 16);
      if (b[i]) ones++;
    end
    if (c[3]) begin
      case (c[5:4])
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      push_level(p, 16);
    end
    push_level(1'b1, c[2] ? ((n == 5) ? 24 : 32) : 16);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tick = 0; m_busy = 0;
      q.delete(); lv_q.delete();
      e_txd = 1; e_hold = 1; e_xmit = 1;
    end else begin
      m_lvl  = m_busy ? lv_q[0] : 1'b1;
      e_txd  = line_cfg[6] ? 1'b0 : ((baud_div == 0) ? 1'b1 : m_lvl);
      e_hold = (q.size() == 0);
      e_xmit = (q.size() == 0) && !m_busy;
      m_done = m_busy && m_tick && (lv_q.size() == 1);
      m_ld   = m_tick && (q.size() > 0) && (!m_busy || m_done);
      if (m_busy && m_tick) begin
        void'(lv_q.pop_front());
        if (lv_q.size() == 0) m_busy = 0;
      end
      if (m_ld) begin
        m_hd = q.pop_front();
        build_frame(m_hd, line_cfg[5:0]);
        m_busy = 1;
      end
      if (fifo_clr) q.delete();
      else if (wr_en && q.size() < 16) q.push_back(wr_byte);
      if (baud_div == 0) begin
        m_cnt = 0; m_tick = 0;
      end else if (m_cnt >= int'(baud_div) - 1) begin
        m_cnt = 0; m_tick = 1;
      end else begin
        m_cnt++; m_tick = 0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (txd !== e_txd || hold_empty !== e_hold || xmit_empty !== e_xmit) begin
        errors++;
        $display("FAIL %s cycle %0d: txd/hold/xmit actual=%b%b%b expected=%b%b%b",
                 cur_req, cycles, txd, hold_empty, xmit_empty, e_txd, e_hold, e_xmit);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(byte unsigned b);
    @(negedge clk); wr_en = 1'b1; wr_byte = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int g = 0; g < 40000 && xmit_empty !== 1'b1; g++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check_eq("R1", {29'd0, txd, hold_empty, xmit_empty}, 32'd7, "reset outputs");
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R3: word lengths, LSB first
    cur_req = "R3";
    line_cfg = 7'h03; send(8'hA5); send(8'h3C); wait_idle();
    for (int w = 0; w < 3; w++) begin
      line_cfg = 7'(w); send(8'h96); wait_idle();
    end

    // R4: parity forms
    cur_req = "R4";
    for (int m = 0; m < 4; m++) begin
      line_cfg = 7'h0B | 7'(m << 4); send(8'hD1); send(8'h70); wait_idle();
    end
    line_cfg = 7'h0A; send(8'h7F); wait_idle();

    // R5: stop lengths
    cur_req = "R5";
    line_cfg = 7'h04; send(8'h15); send(8'h0A); wait_idle();
    line_cfg = 7'h07; send(8'hC3); wait_idle();
    line_cfg = 7'h05; send(8'h2E); wait_idle();

    // R2: start bit width 16*divisor
    cur_req = "R2";
    baud_div = 16'd3; line_cfg = 7'h03;
    send(8'h01);
    begin
      int low;
      int g;
      low = 0;
      g = 0;
      while (txd !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
      while (txd === 1'b0 && low < 2000) begin @(negedge clk); low++; end
      check_eq("R2", low, 48, "start bit cycles");
    end
    wait_idle();
    // R2: divisor zero stops the line
    baud_div = 16'd0; send(8'h00);
    repeat (200) @(negedge clk);
    check_eq("R2", {31'd0, txd}, 1, "txd with zero divisor");
    check_eq("R2", {31'd0, xmit_empty}, 0, "pending byte held");
    baud_div = 16'd2; wait_idle();

    // R6: break overrides line
    cur_req = "R6";
    send(8'h00);
    repeat (40) @(negedge clk);
    line_cfg = 7'h43;
    repeat (100) @(negedge clk);
    check_eq("R6", {31'd0, txd}, 0, "txd under break");
    line_cfg = 7'h03;
    wait_idle();

    // R7: capacity and drop while full
    cur_req = "R7";
    baud_div = 16'd0;
    for (int i = 0; i < 17; i++) send(8'(8'h40 + i));
    check_eq("R7", {31'd0, hold_empty}, 0, "queue holds data");
    baud_div = 16'd1;
    // R7: writes on every cycle hit the pop cycle of the full queue
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_byte = 8'(i);
    end
    @(negedge clk); wr_en = 1'b0;
    wait_idle();

    // R8: clear wins over write, frame in flight completes
    cur_req = "R8";
    baud_div = 16'd2;
    send(8'h11); send(8'h22); send(8'h33);
    repeat (30) @(negedge clk);
    fifo_clr = 1'b1; wr_en = 1'b1; wr_byte = 8'h99;
    @(negedge clk); fifo_clr = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check_eq("R8", {30'd0, hold_empty, xmit_empty}, 2, "after clear");
    wait_idle();
    // R8: clear in the same cycle the byte is taken
    baud_div = 16'd1;
    @(negedge clk); wr_en = 1'b1; wr_byte = 8'h5A;
    @(negedge clk); wr_en = 1'b0; fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R8", {31'd0, xmit_empty}, 0, "taken byte still sent");
    wait_idle();

    // R10: back-to-back frames, shape latched at take
    cur_req = "R10";
    baud_div = 16'd2; line_cfg = 7'h03;
    send(8'hE7); send(8'h18);
    repeat (60) @(negedge clk);
    line_cfg = 7'h00;
    wait_idle();

    // R9 / R11: idle flags and line
    cur_req = "R9";
    check_eq("R9", {30'd0, hold_empty, xmit_empty}, 3, "idle flags");
    check_eq("R11", {31'd0, txd}, 1, "idle line");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    #(5ns * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog %s: actual=running expected=finished", cur_req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule